// File: doc/BRIEF.md
# Aligned Transfer Length Splitter

This block takes one scatter-list entry at a time, given as a start address and a byte length. It breaks the entry into sub-segments small enough for a DMA channel whose byte-count field tops out at 0x1FFF. A long entry is not cut into maximum-size chunks followed by a short leftover. Instead, each piece is sized by dividing what remains into a near-equal number of parts, then rounding the piece down to a 4-byte multiple. The pieces therefore come out roughly equal, stay aligned, and leave no tiny tail.

Entries arrive on a valid/ready input. Pieces leave on a valid/ready output that carries address, length and a flag marking the final piece of the entry. A misaligned start address or an empty entry is consumed, flagged on an error pulse, and produces no piece. The piece-size division uses a shared multi-cycle sequential divider. The input stays stalled until the final piece of the current entry has been taken. A running byte total of accepted entries is exported so that the sum of the pieces can be checked against it.

Top module: `seg_splitter`

## Requirements
- R1: An entry whose start address has bit 1 or bit 0 set is consumed. It raises `err_o` for exactly the one cycle after its handshake and produces no output piece.
- R2: An entry of length zero is rejected the same way as in R1.
- R3: An entry of length 0x1FFF or less is emitted as one piece. That piece has the entry's address and full length, with `out_last_o` = 1.
- R4: While the remaining length R exceeds 0x1FFF, the next piece is computed in three steps: n = ceil(R / 0x1FFC), then floor(R / n), then bits 1:0 of the result are cleared. This is recomputed on each new remaining length, and the final remaining length of 0x1FFF or less is emitted whole.
- R5: Each piece's address is the entry address plus the lengths of all earlier pieces of the entry. Every piece is nonzero and at most 0x1FFF, and the lengths of an entry's pieces sum to its length.
- R6: `out_last_o` is 1 on the final piece of an entry and 0 on all other pieces.
- R7: `in_ready_o` is 0 from the cycle after an entry is accepted until its final piece is accepted. It is 1 in the cycle after that.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, the output address, length and last flag hold their values.
- R9: `total_bytes_o` grows by the entry length one cycle after each accepted, non-rejected entry. It does not change for rejected entries or at any other time.
- R10: After reset, `in_ready_o` = 1, `out_valid_o` = 0, `err_o` = 0 and `total_bytes_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Entry offered |
| in_ready_o | output | 1 | Entry can be taken (idle) |
| in_addr_i | input | ADDR_W | Entry start address |
| in_len_i | input | LEN_W | Entry byte length |
| out_valid_o | output | 1 | Piece offered |
| out_ready_i | input | 1 | Piece taken |
| out_addr_o | output | ADDR_W | Piece address |
| out_len_o | output | LEN_W | Piece byte length |
| out_last_o | output | 1 | Final piece of the entry |
| err_o | output | 1 | One-cycle pulse for a rejected entry |
| total_bytes_o | output | TOT_W | Running byte total of accepted entries |

## Verification
Two results have a fixed timing. The error pulse and the running total are both due in the cycle right after the input handshake, and the bench samples them at the following falling edge. The output pieces have no fixed latency, because a long remainder goes through two divider passes while a short one needs none. The bench therefore waits at each falling edge for `out_valid_o` and compares a piece only in a cycle where it also asserts ready. It confirms that the input reopens at the falling edge after the final piece is taken. Stalled cycles under random back-pressure are compared against the values held from the previous cycle.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_DIV_CNT,
    S_DIV_LEN,
    S_EMIT
  } split_state_e;
endpackage

// File: rtl/seg_split_div.sv
// Restoring unsigned divider, W cycles per operation.
module seg_split_div #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    acc_q;
  logic [W-1:0]  quot_q, dvs_q;
  logic [W:0]    shifted;
  logic          fits;

  assign shifted = {acc_q[W-1:0], quot_q[W-1]};
  assign fits    = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      quot_q <= '0;
      dvs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(W);
        acc_q  <= '0;
        quot_q <= dividend_i;
        dvs_q  <= divisor_i;
      end else if (busy_q) begin
        acc_q  <= fits ? (shifted - {1'b0, dvs_q}) : shifted;
        quot_q <= {quot_q[W-2:0], fits};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;
endmodule

// File: rtl/seg_split_acc.sv
module seg_split_acc #(
  parameter int LEN_W = 16,
  parameter int TOT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [LEN_W-1:0] val_i,
  output logic [TOT_W-1:0] total_o
);
  logic [TOT_W-1:0] total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    total_q <= '0;
    else if (add_i) total_q <= total_q + {{(TOT_W-LEN_W){1'b0}}, val_i};
  end

  assign total_o = total_q;
endmodule

// File: rtl/seg_splitter.sv
module seg_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int TOT_W      = 32,
  parameter int MAX_SEG    = 'h1FFF,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [LEN_W-1:0]  in_len_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [LEN_W-1:0]  out_len_o,
  output logic              out_last_o,
  output logic              err_o,
  output logic [TOT_W-1:0]  total_bytes_o
);
  import seg_split_pkg::*;

  localparam int DW         = LEN_W + 1;
  localparam int ALIGN_MASK = (1 << ALIGN_BITS) - 1;
  localparam int CHUNK      = MAX_SEG & ~ALIGN_MASK;

  split_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, piece_q;
  logic              err_q;

  logic              in_fire, in_bad, out_fire, rem_big;
  logic              div_start, div_done;
  logic [DW-1:0]     div_dividend, div_divisor, div_quot;
  logic [LEN_W-1:0]  piece_div;

  assign in_ready_o = (state_q == S_IDLE);
  assign in_fire    = in_valid_i & in_ready_o;
  assign in_bad     = (in_addr_i[ALIGN_BITS-1:0] != '0) || (in_len_i == '0);
  assign out_fire   = out_valid_o & out_ready_i;
  assign rem_big    = rem_q > LEN_W'(MAX_SEG);

  // pass 1: ceil(rem / CHUNK); pass 2: rem / count
  assign div_start    = ((state_q == S_EVAL) && rem_big) ||
                        ((state_q == S_DIV_CNT) && div_done);
  assign div_dividend = (state_q == S_EVAL) ? ({1'b0, rem_q} + DW'(CHUNK - 1))
                                            : {1'b0, rem_q};
  assign div_divisor  = (state_q == S_EVAL) ? DW'(CHUNK) : div_quot;
  assign piece_div    = div_quot[LEN_W-1:0] & ~LEN_W'(ALIGN_MASK);

  seg_split_div #(.W(DW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_dividend),
    .divisor_i  (div_divisor),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  seg_split_acc #(.LEN_W(LEN_W), .TOT_W(TOT_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .add_i   (in_fire & ~in_bad),
    .val_i   (in_len_i),
    .total_o (total_bytes_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      piece_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (in_fire) begin
          if (in_bad) begin
            err_q <= 1'b1;
          end else begin
            addr_q  <= in_addr_i;
            rem_q   <= in_len_i;
            state_q <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (rem_big) begin
            state_q <= S_DIV_CNT;
          end else begin
            piece_q <= rem_q;
            state_q <= S_EMIT;
          end
        end
        S_DIV_CNT: if (div_done) state_q <= S_DIV_LEN;
        S_DIV_LEN: if (div_done) begin
          piece_q <= piece_div;
          state_q <= S_EMIT;
        end
        S_EMIT: if (out_fire) begin
          addr_q  <= addr_q + ADDR_W'(piece_q);
          rem_q   <= rem_q - piece_q;
          state_q <= (piece_q == rem_q) ? S_IDLE : S_EVAL;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign out_valid_o = (state_q == S_EMIT);
  assign out_addr_o  = addr_q;
  assign out_len_o   = piece_q;
  assign out_last_o  = (piece_q == rem_q);
  assign err_o       = err_q;
endmodule

// File: rtl/seg_split_chk.sv
module seg_split_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int TOT_W      = 32,
  parameter int MAX_SEG    = 'h1FFF,
  parameter int ALIGN_BITS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [ADDR_W-1:0] in_addr_i,
  input logic [LEN_W-1:0]  in_len_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [LEN_W-1:0]  out_len_o,
  input logic              out_last_o,
  input logic              err_o,
  input logic [TOT_W-1:0]  total_bytes_o
);
  a_r1_misalign_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && (in_addr_i[ALIGN_BITS-1:0] != '0)) |=> (err_o && !out_valid_o));

  a_r2_zero_len_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && (in_len_i == '0)) |=> (err_o && !out_valid_o));

  a_r5_piece_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_len_o != '0) && (out_len_o <= LEN_W'(MAX_SEG))));

  a_r4_piece_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |-> (out_len_o[ALIGN_BITS-1:0] == '0));

  a_r7_input_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r7_reopen_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |=> in_ready_o);

  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_addr_o) && $stable(out_len_o) && $stable(out_last_o)));

  a_r9_total_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> $stable(total_bytes_o));
endmodule

bind seg_splitter seg_split_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TOT_W(TOT_W), .MAX_SEG(MAX_SEG), .ALIGN_BITS(ALIGN_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_addr_i(in_addr_i), .in_len_i(in_len_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_addr_o(out_addr_o), .out_len_o(out_len_o),
  .out_last_o(out_last_o), .err_o(err_o), .total_bytes_o(total_bytes_o)
);

// File: tb/tb_seg_splitter.sv
`timescale 1ns/1ps
module tb_seg_splitter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_addr_i = '0;
  logic [15:0] in_len_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_addr_o;
  logic [15:0] out_len_o;
  logic        out_last_o;
  logic        err_o;
  logic [31:0] total_bytes_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] exp_total = '0;

  always #2.5 clk_i = ~clk_i;

  seg_splitter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_addr_i(in_addr_i), .in_len_i(in_len_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_addr_o(out_addr_o), .out_len_o(out_len_o),
    .out_last_o(out_last_o), .err_o(err_o), .total_bytes_o(total_bytes_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act cycles %0d exp < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_piece(input int rem);
    int n;
    if (rem <= 'h1FFF) return rem;
    n = (rem + 'h1FFC - 1) / 'h1FFC;
    return (rem / n) & ~3;
  endfunction

  task automatic run_entry(input logic [31:0] a, input logic [15:0] l, input bit always_rdy);
    bit bad;
    logic [31:0] ea;
    int rem, waited, ep;
    bit stall;
    logic [31:0] s_addr;
    logic [15:0] s_len;
    logic s_last;
    bad = (a[1:0] != 2'b00) || (l == 16'd0);
    @(negedge clk_i);
    check(in_ready_o == 1'b1, "R7 idle ready", in_ready_o, 1);
    in_valid_i = 1'b1; in_addr_i = a; in_len_i = l;
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    if (!bad) exp_total = exp_total + 32'(l);
    check(err_o == bad, (l == 0) ? "R2 err pulse" : "R1 err pulse", err_o, bad);
    check(total_bytes_o == exp_total, "R9 total", total_bytes_o, exp_total);
    if (bad) begin
      check(out_valid_o == 1'b0, (l == 0) ? "R2 no piece" : "R1 no piece", out_valid_o, 0);
      @(negedge clk_i);
      check(err_o == 1'b0, "R1 err one cycle", err_o, 0);
      check(out_valid_o == 1'b0 && in_ready_o == 1'b1, "R1 still idle", out_valid_o, 0);
      return;
    end
    ea = a; rem = int'(l); waited = 0; stall = 0;
    s_addr = '0; s_len = '0; s_last = 1'b0;
    while (rem > 0 && waited < 4000) begin
      bit rdy;
      rdy = always_rdy || ($urandom % 4 != 0);
      if (out_valid_o) begin
        check(in_ready_o == 1'b0, "R7 stalled", in_ready_o, 0);
        if (stall)
          check(out_addr_o == s_addr && out_len_o == s_len && out_last_o == s_last,
                "R8 hold", out_len_o, s_len);
        if (rdy) begin
          ep = exp_piece(rem);
          check(out_addr_o == ea, "R5 addr", out_addr_o, ea);
          check(int'(out_len_o) == ep, (l <= 16'h1FFF) ? "R3 len" : "R4 len", out_len_o, ep);
          check(out_last_o == (ep == rem), "R6 last", out_last_o, (ep == rem));
          ea = ea + 32'(ep);
          rem = rem - ep;
          stall = 0;
        end else begin
          stall = 1; s_addr = out_addr_o; s_len = out_len_o; s_last = out_last_o;
        end
      end
      out_ready_i = rdy;
      @(posedge clk_i);
      @(negedge clk_i);
      waited++;
    end
    out_ready_i = 1'b0;
    check(rem == 0, "R5 pieces sum", rem, 0);
    check(in_ready_o == 1'b1, "R7 reopen", in_ready_o, 1);
    check(out_valid_o == 1'b0, "R6 no extra piece", out_valid_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    #1;
    check(in_ready_o == 1'b1, "R10 ready", in_ready_o, 1);
    check(out_valid_o == 1'b0, "R10 valid", out_valid_o, 0);
    check(err_o == 1'b0, "R10 err", err_o, 0);
    check(total_bytes_o == 32'd0, "R10 total", total_bytes_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    run_entry(32'h1000_0000, 16'h1FFF, 1'b1);   // R3 max single
    run_entry(32'h1000_4000, 16'd1,    1'b1);   // R3 smallest
    run_entry(32'h2000_0000, 16'h2000, 1'b0);   // R4 just over
    run_entry(32'h2000_8000, 16'h4000, 1'b0);   // R4 three pieces
    run_entry(32'h3000_0000, 16'hFFFF, 1'b0);   // R4 widest
    run_entry(32'h3000_0001, 16'h0100, 1'b1);   // R1 misaligned
    run_entry(32'h3000_0002, 16'h3000, 1'b1);   // R1 misaligned
    run_entry(32'h3000_0004, 16'h0000, 1'b1);   // R2 zero length
    run_entry(32'h4000_0000, 16'h3FFB, 1'b0);   // R4 odd tail

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      logic [15:0] l;
      a = $urandom;
      if ($urandom % 8 != 0) a[1:0] = 2'b00;
      l = 16'($urandom);
      if ($urandom % 3 == 0) l = 16'($urandom % 'h2400);
      if ($urandom % 20 == 0) l = 16'd0;
      run_entry(a, l, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule